// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 64-bit virtual address into a physical address for one memory access. A request carries the address, the page table base, the kind of access wanted (read, write, execute, as a bit mask) and a two-bit privilege mode index, where 0 is kernel. The walker first screens the address. A non-canonical address fails at once. An address in the kernel's direct-mapped superpage window is translated with no memory traffic. Every other address is resolved by reading one 8-byte entry at each of three table levels through a simple read request/response port.

Each walk ends with a one-cycle `done` pulse. The pulse carries the physical address, the granted read/write/execute set and a three-bit fault code. Pages are 8 KB (13 offset bits) and each level is indexed by 10 address bits. The walker takes one request at a time. While a walk is in progress, new requests are dropped without effect.

Top module: `ptw_walker`

## Requirements
- R1: An address whose bits 63:43 are not all equal completes with fault code 1 (access violation), with `done` high in the cycle after acceptance and no memory read.
- R2: A canonical address with bit 63 set and bits 42:41 equal to binary 10 is a superpage address. In any mode other than 0 it completes with fault 1 and no memory read.
- R3: A superpage address in mode 0 completes with fault 0, prot 3'b111 and no memory read. The physical address is virtual bits 39:0, with virtual bit 40 placed at physical bit 43 and all other bits zero.
- R4: A walk reads the first-level entry at ptbr + va[42:33]*8, then the second-level entry at T1 + va[32:23]*8, then the third-level entry at T2 + va[22:13]*8. T1 and T2 are the upper 32 bits of the previous entry shifted left by 13. No further reads are issued after a walk stops.
- R5: An entry whose bit 0 (valid) is clear, at any level, stops the walk with fault code 2 (not valid).
- R6: A first- or second-level entry that is valid but has bit 8 (kernel read enable) clear stops the walk with fault 1.
- R7: At the third level, read and execute are granted when entry bit 8+mode is set, and write is granted when entry bit 12+mode is set. prot and need use bit 0 = read, bit 1 = write, bit 2 = execute. A non-zero need with no bit granted gives fault 1.
- R8: Entry bits 1, 2 and 3 remove read, write and execute respectively from the granted set. If need is non-zero and none of it remains, the fault is chosen by the need mask: 5 if the execute bit is set, else 4 if the write bit is set, else 3 (read). A need of zero never faults here.
- R9: A successful walk reports the remaining permissions as prot. The physical address is the third-level entry's upper 32 bits shifted left by 13, OR'd with virtual bits 12:0.
- R10: Whenever the fault code is non-zero, phys_addr and prot are zero.
- R11: After reset, done, mem_req, fault, prot and phys_addr are zero. done is high for exactly one cycle per completed walk.
- R12: A request presented while mem_req is high is ignored. The running walk completes with its own result.
- R13: mem_req stays high with a stable mem_addr until mem_rvalid is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation (taken when idle) |
| req_va | input | 64 | Virtual address |
| req_ptbr | input | 64 | First-level table base address |
| req_need | input | 3 | Access needed: bit0 read, bit1 write, bit2 execute |
| req_mode | input | 2 | Privilege mode index, 0 = kernel |
| mem_req | output | 1 | Table read outstanding; high for the whole walk |
| mem_addr | output | 64 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Table entry returned |
| done | output | 1 | One-cycle completion strobe |
| phys_addr | output | 64 | Translated address (zero on fault) |
| prot | output | 3 | Granted set: bit0 read, bit1 write, bit2 execute |
| fault | output | 3 | 0 ok, 1 access violation, 2 not valid, 3/4/5 fault on read/write/execute |

## Verification
The hardest cases to reach are the ones where the leaf grants only part of a multi-bit need and the fault-on bits then remove what was granted, so the reported fault follows the need mask rather than what was actually blocked. Random leaf entries rarely line up this way, so a directed table path under a reserved first-level index is rewritten entry by entry. It exercises each fault-on rank, an empty need, a missing level-one valid bit and a cleared kernel-read bit at both upper levels. A request injected while a walk waits on memory, and a responder that delays each read by a random 0 to 3 cycles, reach the ignore and hold rules. Random walks build their tables lazily over a fixed-seed stream of canonical, superpage and non-canonical addresses.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_ACV  = 3'd1,
        FLT_TNV  = 3'd2,
        FLT_FOR  = 3'd3,
        FLT_FOW  = 3'd4,
        FLT_FOE  = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LVL1,
        ST_LVL2,
        ST_LVL3
    } walk_st_e;

    typedef struct packed {
        logic [63:0] pa;
        logic [2:0]  prot;
        fault_e      fault;
    } walk_res_t;

    // entry bit positions
    localparam int PTE_V       = 0;
    localparam int PTE_FO_LO   = 1;
    localparam int PTE_RD_BASE = 8;
    localparam int PTE_WR_BASE = 12;

    // superpage window and remap
    localparam int         SP_LOW_BITS  = 40;
    localparam int         SP_MOVED_BIT = 43;
    localparam int         SP_SEL_LO    = 41;
    localparam logic [1:0] SP_SEL_VAL   = 2'b10;

    localparam logic [2:0] PROT_ALL = 3'b111;

    function automatic logic [63:0] entry_addr(logic [63:0] base, logic [63:0] idx);
        return base + (idx << 3);
    endfunction

    function automatic logic [63:0] frame_of(logic [63:0] pte, int pbits);
        return {32'b0, pte[63:32]} << pbits;
    endfunction

    function automatic walk_res_t make_result(fault_e f, logic [2:0] p, logic [63:0] a);
        walk_res_t r;
        r.fault = f;
        r.prot  = (f == FLT_NONE) ? p : 3'b0;
        r.pa    = (f == FLT_NONE) ? a : 64'b0;
        return r;
    endfunction

endpackage

// File: rtl/ptw_va_screen.sv
module ptw_va_screen
    import ptw_pkg::*;
#(
    parameter int VA_BITS = 43
) (
    input  logic [63:0] va,
    output logic        canon,
    output logic        is_super,
    output logic [63:0] super_pa
);
    localparam int HI_W = 64 - VA_BITS;

    logic [HI_W-1:0] hi;

    always_comb begin
        hi       = va[63:VA_BITS];
        canon    = (hi == '0) || (hi == '1);
        is_super = va[63] && (va[SP_SEL_LO+1:SP_SEL_LO] == SP_SEL_VAL);
        super_pa = 64'(va[SP_LOW_BITS-1:0])
                 | (64'(va[SP_LOW_BITS]) << SP_MOVED_BIT);
    end
endmodule

// File: rtl/ptw_leaf_perm.sv
module ptw_leaf_perm
    import ptw_pkg::*;
#(
    parameter int MODE_BITS = 2
) (
    input  logic [15:0]          pte,
    input  logic [2:0]           need,
    input  logic [MODE_BITS-1:0] mode,
    output logic [2:0]           prot,
    output fault_e               fault
);
    localparam int NMODES = 1 << MODE_BITS;

    logic [NMODES-1:0] rd_en, wr_en;
    logic [2:0]        granted, kept;
    logic              unused_mid;

    assign unused_mid = ^pte[7:4];

    always_comb begin
        rd_en   = pte[PTE_RD_BASE +: NMODES];
        wr_en   = pte[PTE_WR_BASE +: NMODES];
        granted = {rd_en[mode], wr_en[mode], rd_en[mode]};
        kept    = granted & ~pte[PTE_FO_LO +: 3];
        prot    = kept;
        fault   = FLT_NONE;
        if (!pte[PTE_V]) begin
            fault = FLT_TNV;
        end else if ((need != 3'b0) && ((granted & need) == 3'b0)) begin
            fault = FLT_ACV;
        end else if ((need != 3'b0) && ((kept & need) == 3'b0)) begin
            if (need[2])      fault = FLT_FOE;
            else if (need[1]) fault = FLT_FOW;
            else              fault = FLT_FOR;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_BITS   = 43,
    parameter int PAGE_BITS = 13,
    parameter int IDX_BITS  = 10,
    parameter int MODE_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [63:0]          req_va,
    input  logic [63:0]          req_ptbr,
    input  logic [2:0]           req_need,
    input  logic [MODE_BITS-1:0] req_mode,
    output logic                 mem_req,
    output logic [63:0]          mem_addr,
    input  logic                 mem_rvalid,
    input  logic [63:0]          mem_rdata,
    output logic                 done,
    output logic [63:0]          phys_addr,
    output logic [2:0]           prot,
    output logic [2:0]           fault
);
    localparam int          SH_L1    = PAGE_BITS + 2 * IDX_BITS;
    localparam int          SH_L2    = PAGE_BITS + IDX_BITS;
    localparam int          SH_L3    = PAGE_BITS;
    localparam logic [63:0] IDX_MASK = (64'd1 << IDX_BITS) - 64'd1;
    localparam logic [63:0] OFF_MASK = (64'd1 << PAGE_BITS) - 64'd1;

    walk_st_e              st;
    logic [63:0]           va_q, addr_q;
    logic [2:0]            need_q;
    logic [MODE_BITS-1:0]  mode_q;
    walk_res_t             res_q;
    logic                  done_q;

    logic                  canon, is_super;
    logic [63:0]           super_pa;
    logic [2:0]            leaf_prot;
    fault_e                leaf_fault;
    logic [63:0]           idx_l1, idx_l2, idx_l3;
    logic                  unused_data;

    assign unused_data = ^mem_rdata[31:16];

    ptw_va_screen #(.VA_BITS(VA_BITS)) u_screen (
        .va       (req_va),
        .canon    (canon),
        .is_super (is_super),
        .super_pa (super_pa)
    );

    ptw_leaf_perm #(.MODE_BITS(MODE_BITS)) u_leaf (
        .pte   (mem_rdata[15:0]),
        .need  (need_q),
        .mode  (mode_q),
        .prot  (leaf_prot),
        .fault (leaf_fault)
    );

    always_comb begin
        idx_l1 = (req_va >> SH_L1) & IDX_MASK;
        idx_l2 = (va_q   >> SH_L2) & IDX_MASK;
        idx_l3 = (va_q   >> SH_L3) & IDX_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            va_q   <= '0;
            addr_q <= '0;
            need_q <= '0;
            mode_q <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_va;
                        need_q <= req_need;
                        mode_q <= req_mode;
                        if (!canon) begin
                            res_q  <= make_result(FLT_ACV, 3'b0, 64'b0);
                            done_q <= 1'b1;
                        end else if (is_super) begin
                            res_q  <= make_result((req_mode == '0) ? FLT_NONE : FLT_ACV,
                                                  PROT_ALL, super_pa);
                            done_q <= 1'b1;
                        end else begin
                            addr_q <= entry_addr(req_ptbr, idx_l1);
                            st     <= ST_LVL1;
                        end
                    end
                end
                ST_LVL1, ST_LVL2: begin
                    if (mem_rvalid) begin
                        if (!mem_rdata[PTE_V]) begin
                            res_q  <= make_result(FLT_TNV, 3'b0, 64'b0);
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                        end else if (!mem_rdata[PTE_RD_BASE]) begin
                            res_q  <= make_result(FLT_ACV, 3'b0, 64'b0);
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                        end else begin
                            addr_q <= entry_addr(frame_of(mem_rdata, PAGE_BITS),
                                                 (st == ST_LVL1) ? idx_l2 : idx_l3);
                            st     <= (st == ST_LVL1) ? ST_LVL2 : ST_LVL3;
                        end
                    end
                end
                ST_LVL3: begin
                    if (mem_rvalid) begin
                        res_q  <= make_result(leaf_fault, leaf_prot,
                                              frame_of(mem_rdata, PAGE_BITS) | (va_q & OFF_MASK));
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_req   = (st != ST_IDLE);
    assign mem_addr  = addr_q;
    assign done      = done_q;
    assign phys_addr = res_q.pa;
    assign prot      = res_q.prot;
    assign fault     = res_q.fault;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R10
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault != 3'd0) |-> (phys_addr == 64'b0 && prot == 3'b0));

    // R8
    foe_need_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault == 3'd5) |-> need_q[2]);

    // R1
    noncanon_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mem_req && !canon) |=> (done && fault == 3'd1 && !mem_req));

    // R2
    super_user_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mem_req && canon && is_super && req_mode != '0)
            |=> (done && fault == 3'd1 && !mem_req));
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    localparam logic [63:0] PTBR = 64'h0000_0002_0000_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [63:0] req_va, req_ptbr;
    logic [2:0]  req_need;
    logic [1:0]  req_mode;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid;
    logic [63:0] mem_rdata;
    logic        done;
    logic [63:0] phys_addr;
    logic [2:0]  prot, fault;

    int checks = 0;
    int errors = 0;

    logic [63:0] mem [logic [63:0]];
    logic [63:0] rd_log[$];
    logic [63:0] exp_log[$];

    always #4 clk = ~clk;

    ptw_walker dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_ptbr(req_ptbr), .req_need(req_need), .req_mode(req_mode),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .phys_addr(phys_addr),
        .prot(prot), .fault(fault)
    );

    function automatic logic [63:0] mread(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'b0;
    endfunction

    // memory responder with random latency; also checks R13
    initial begin
        logic [63:0] cap;
        mem_rvalid = 1'b0;
        mem_rdata  = 64'b0;
        forever begin
            @(negedge clk);
            if (mem_req && !rst) begin
                cap = mem_addr;
                rd_log.push_back(cap);
                repeat ($urandom_range(0, 3)) @(negedge clk);
                checks++;
                if (!mem_req || mem_addr !== cap) begin
                    errors++;
                    $display("FAIL R13: req=%0b addr=%h expected req=1 addr=%h", mem_req, mem_addr, cap);
                end
                mem_rdata  = mread(cap);
                mem_rvalid = 1'b1;
                @(negedge clk);
                mem_rvalid = 1'b0;
            end
        end
    end

    function automatic logic noncanon(input logic [63:0] va);
        return (($signed(va) >>> 43) != ($signed(va) >>> 63));
    endfunction

    task automatic ref_walk(input logic [63:0] va, input logic [2:0] need, input logic [1:0] mode,
                            output logic [2:0] f, output logic [2:0] p, output logic [63:0] pa,
                            output string tag);
        logic [63:0] base, pte, a;
        logic [9:0]  idx;
        logic [2:0]  g, e;
        f = 3'd0; p = 3'd0; pa = 64'b0; tag = "R9";
        pte = 64'b0;
        exp_log.delete();
        if (noncanon(va)) begin f = 3'd1; tag = "R1"; return; end
        if (va[63] && va[42:41] == 2'b10) begin
            if (mode != 2'd0) begin f = 3'd1; tag = "R2"; end
            else begin p = 3'd7; pa = {20'b0, va[40], 3'b0, va[39:0]}; tag = "R3"; end
            return;
        end
        base = PTBR;
        for (int lvl = 0; lvl < 3; lvl++) begin
            idx = va[13 + 10 * (2 - lvl) +: 10];
            a   = base + {51'b0, idx, 3'b0};
            exp_log.push_back(a);
            pte = mread(a);
            if (!pte[0]) begin f = 3'd2; tag = "R5"; return; end
            if (lvl < 2) begin
                if (!pte[8]) begin f = 3'd1; tag = "R6"; return; end
                base = {19'b0, pte[63:32], 13'b0};
            end
        end
        g = {pte[8 + mode], pte[12 + mode], pte[8 + mode]};
        if (need != 3'd0 && (g & need) == 3'd0) begin f = 3'd1; tag = "R7"; return; end
        e = g & ~pte[3:1];
        if (need != 3'd0 && (e & need) == 3'd0) begin
            f = need[2] ? 3'd5 : (need[1] ? 3'd4 : 3'd3);
            tag = "R8";
            return;
        end
        p  = e;
        pa = {19'b0, pte[63:32], 13'b0} | {51'b0, va[12:0]};
    endtask

    task automatic walk_check(input logic [63:0] va, input logic [2:0] need,
                              input logic [1:0] mode, input bit inject);
        logic [2:0]  ef, ep;
        logic [63:0] epa;
        string       tag;
        int          t;
        bit          same;
        ref_walk(va, need, mode, ef, ep, epa, tag);
        if (ef != 3'd0) tag = {tag, " R10"};
        if (inject) tag = {tag, " R12"};
        rd_log.delete();
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_need = need; req_mode = mode;
        @(negedge clk);
        req_valid = 1'b0;
        if (inject && mem_req) begin
            req_valid = 1'b1; req_va = 64'h0100_0000_0000_0000; req_need = 3'b001; req_mode = 2'd0;
            @(negedge clk);
            req_valid = 1'b0;
        end
        t = 0;
        while (!done && t < 100) begin @(negedge clk); t++; end
        checks++;
        if (!done || fault !== ef || prot !== ep || phys_addr !== epa) begin
            errors++;
            $display("FAIL %s: va=%h done=%0b fault=%0d prot=%0d pa=%h expected fault=%0d prot=%0d pa=%h",
                     tag, va, done, fault, prot, phys_addr, ef, ep, epa);
        end
        same = (rd_log.size() == exp_log.size());
        if (same) foreach (exp_log[k]) if (rd_log[k] !== exp_log[k]) same = 1'b0;
        checks++;
        if (!same) begin
            errors++;
            $display("FAIL R4: va=%h reads=%0d first=%h expected reads=%0d first=%h", va,
                     rd_log.size(), (rd_log.size() > 0) ? rd_log[0] : 64'b0,
                     exp_log.size(), (exp_log.size() > 0) ? exp_log[0] : 64'b0);
        end
        @(negedge clk);
        checks++;
        if (done !== 1'b0) begin
            errors++;
            $display("FAIL R11: done=%0b one cycle after completion, expected 0", done);
        end
    endtask

    function automatic logic [63:0] table_pte();
        logic [63:0] e;
        e = {12'b0, 20'($urandom_range(0, 32'h7FFFF)), 32'b0};
        if ($urandom_range(0, 15) != 0) e[0] = 1'b1;
        if ($urandom_range(0, 15) != 0) e[8] = 1'b1;
        return e;
    endfunction

    function automatic logic [63:0] leaf_pte();
        logic [63:0] e;
        e = {$urandom, 16'b0, 16'($urandom)};
        e[0] = ($urandom_range(0, 7) != 0);
        if ($urandom_range(0, 1) == 1) e[3:1] = 3'b0;
        return e;
    endfunction

    task automatic populate(input logic [63:0] va);
        logic [63:0] a, base, e;
        if (noncanon(va)) return;
        if (va[63] && va[42:41] == 2'b10) return;
        base = PTBR;
        for (int lvl = 0; lvl < 3; lvl++) begin
            a = base + {51'b0, va[13 + 10 * (2 - lvl) +: 10], 3'b0};
            if (!mem.exists(a)) mem[a] = (lvl < 2) ? table_pte() : leaf_pte();
            e = mem[a];
            if (lvl < 2) begin
                if (!(e[0] && e[8])) return;
                base = {19'b0, e[63:32], 13'b0};
            end
        end
    endtask

    task automatic set_leaf(input logic [63:0] va, input logic [63:0] pte3);
        mem[PTBR + {51'b0, va[42:33], 3'b0}] = 64'h000F_0000_0000_0101;
        mem[{19'b0, 32'h000F_0000, 13'b0} + {51'b0, va[32:23], 3'b0}] = 64'h000F_0001_0000_0101;
        mem[{19'b0, 32'h000F_0001, 13'b0} + {51'b0, va[22:13], 3'b0}] = pte3;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11: watchdog expired, actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] vd, v;
        int unsigned seed;
        seed = $urandom(32'd4711);
        rst = 1'b1; req_valid = 1'b0; req_va = '0; req_ptbr = PTBR; req_need = '0; req_mode = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (done !== 1'b0 || mem_req !== 1'b0 || fault !== 3'd0 || prot !== 3'd0 || phys_addr !== 64'b0) begin
            errors++;
            $display("FAIL R11: reset done=%0b req=%0b fault=%0d prot=%0d pa=%h expected all zero",
                     done, mem_req, fault, prot, phys_addr);
        end

        // R1 non-canonical, positive and negative forms
        walk_check(64'h0001_0000_0000_0000, 3'b001, 2'd0, 1'b0);
        walk_check(64'hFFF0_0000_0000_0000, 3'b100, 2'd3, 1'b0);
        // R3 superpage in kernel, R2 in user
        walk_check(64'hFFFF_FD23_4567_89AB, 3'b010, 2'd0, 1'b0);
        walk_check(64'hFFFF_FD23_4567_89AB, 3'b001, 2'd3, 1'b0);
        walk_check(64'hFFFF_FC00_0000_0010, 3'b000, 2'd1, 1'b0);

        // directed path: idx1=0x1FF idx2=5 idx3=7 offset 0x123
        vd = 64'h0000_03FE_0280_E123;
        set_leaf(vd, 64'h0001_2345_0000_FF01);
        walk_check(vd, 3'b001, 2'd2, 1'b0);          // R9
        walk_check(vd, 3'b111, 2'd3, 1'b1);          // R12 ignored request
        set_leaf(vd, 64'h0001_2345_0000_1801);
        walk_check(vd, 3'b010, 2'd3, 1'b0);          // R7 write not granted to user
        walk_check(vd, 3'b101, 2'd3, 1'b0);          // R7 read granted to user
        walk_check(vd, 3'b010, 2'd0, 1'b0);          // R7 kernel write
        set_leaf(vd, 64'h0001_2345_0000_FF0F);
        walk_check(vd, 3'b111, 2'd0, 1'b0);          // R8 execute ranks first
        walk_check(vd, 3'b011, 2'd1, 1'b0);          // R8 write next
        walk_check(vd, 3'b001, 2'd2, 1'b0);          // R8 read last
        walk_check(vd, 3'b000, 2'd0, 1'b0);          // R8 empty need succeeds
        set_leaf(vd, 64'h0001_2345_0000_FF03);
        walk_check(vd, 3'b011, 2'd0, 1'b0);          // R8 read removed, write kept
        set_leaf(vd, 64'h0001_2345_0000_FF00);
        walk_check(vd, 3'b001, 2'd0, 1'b0);          // R5 leaf invalid
        set_leaf(vd, 64'h0001_2345_0000_FF01);
        mem[PTBR + {51'b0, vd[42:33], 3'b0}] = 64'h000F_0000_0000_0100;
        walk_check(vd, 3'b001, 2'd0, 1'b0);          // R5 level one invalid
        mem[PTBR + {51'b0, vd[42:33], 3'b0}] = 64'h000F_0000_0000_0001;
        walk_check(vd, 3'b001, 2'd0, 1'b0);          // R6 level one kernel read clear
        set_leaf(vd, 64'h0001_2345_0000_FF01);
        mem[{19'b0, 32'h000F_0000, 13'b0} + {51'b0, vd[32:23], 3'b0}] = 64'h000F_0001_0000_0001;
        walk_check(vd, 3'b001, 2'd0, 1'b0);          // R6 level two kernel read clear
        set_leaf(vd, 64'h0001_2345_0000_FF01);

        // random walks
        for (int i = 0; i < 400; i++) begin
            v = {$urandom, $urandom};
            v = {{21{v[42]}}, v[42:0]};
            if (v[42:33] == 10'h1FF) v[33] = ~v[33];
            if ($urandom_range(0, 15) == 0) v[55] = ~v[55];
            populate(v);
            walk_check(v, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), (i % 25) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule